// File: doc/BRIEF.md
# System Management Mode Entry and Nesting Controller

This block keeps track of whether a processor core is running in system management mode. It takes single-cycle event pulses for a management interrupt (SMI), a non-maskable interrupt (NMI) and a resume request. It also takes a programmed management region, given as a base address and a size code, and two enable bits: one that permits nested SMIs and one that permits NMIs. From these it produces the in-mode flag, the nested-status bit that the core writes into the saved state header, the captured entry vector and a one-cycle pulse that clears the interrupt-enable flag on every entry. It also raises a service request for one held-back NMI.

Saving and restoring the header and running the handler are not part of this block; they appear here only as pulses. When a resume request is made, the nested bit of the header being restored comes in alongside it. A combinational decoder reports whether an access address lies inside the management region. Such an access is always marked cacheable. A region that is not legal is flagged as an error and prevents any SMI from being taken.

Top module: `smm_ctrl`

## Requirements
- R1: After reset, `in_smm`, `if_clear`, `hdr_nested` and `nmi_svc_req` are 0, and `entry_vec` is 0.
- R2: An SMI pulse outside the mode with a legal region sets `in_smm` on the next edge. At that edge `if_clear` pulses high for exactly one cycle, `hdr_nested` is 0 and `entry_vec` equals `cfg_base`.
- R3: `cfg_size` is log2 of the region size in bytes. It is legal from 12 (4 KB) to 25 (32 MB), and the base must have all address bits below that size clear. Otherwise `cfg_err` is 1 and an SMI is dropped: it is neither taken nor held.
- R4: An SMI that arrives in the mode while `nest_en` is 1 re-enters the mode. It pulses `if_clear` and sets `hdr_nested` to 1.
- R5: An SMI that arrives in the mode while `nest_en` is 0 is not taken. It is held and is taken one cycle after the resume that leaves the mode, with `hdr_nested` 0.
- R6: A resume pulse in the mode loads `in_smm` from `rsm_hdr_nested` on the next edge. A resume pulse outside the mode has no effect.
- R7: An NMI that arrives in the mode while `nmi_en` is 0 is held and `nmi_svc_req` stays 0. The request rises in the same cycle that `nmi_en` goes to 1, or in the cycle after a resume that leaves the mode.
- R8: Only one NMI is held; further NMIs that arrive while one is held are dropped. An `nmi_ack` given while `nmi_svc_req` is high clears it on the next edge.
- R9: An NMI pulse outside the mode raises `nmi_svc_req` on the next edge.
- R10: `acc_in_region` and `acc_cacheable` are 1 exactly when `cfg_err` is 0 and `acc_addr` lies in [`cfg_base`, `cfg_base` + 2^`cfg_size`).
- R11: When a resume and an SMI arrive in the same cycle in the mode, the resume is carried out first. The SMI is held under R5 and is taken one cycle later if the resume left the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_base | input | AW | Region base address |
| cfg_size | input | SZW | Region size as log2 of bytes |
| nest_en | input | 1 | Permit SMI while in the mode |
| nmi_en | input | 1 | Permit NMI service while in the mode |
| smi_req | input | 1 | SMI event pulse |
| nmi_req | input | 1 | NMI event pulse |
| nmi_ack | input | 1 | Core accepts the NMI service request |
| rsm_req | input | 1 | Resume pulse |
| rsm_hdr_nested | input | 1 | Nested bit of the header being restored |
| acc_addr | input | AW | Access address to classify |
| in_smm | output | 1 | Core is in the management mode |
| hdr_nested | output | 1 | Nested bit for the header of the latest entry |
| entry_vec | output | AW | Base captured at the latest entry |
| if_clear | output | 1 | One-cycle pulse forcing interrupts disabled |
| nmi_svc_req | output | 1 | Held NMI requests service |
| cfg_err | output | 1 | Region base or size is not legal |
| acc_in_region | output | 1 | Access address falls in the region |
| acc_cacheable | output | 1 | Access is marked cacheable |

## Verification
The mode flag, the entry pulse, the nested bit and the entry vector all come from registers, so each is due one edge after the pulse that causes it. A held SMI is due one edge after the resume that leaves the mode, which makes it two edges after that resume pulse was driven. The NMI request is registered with respect to NMI pulses and acknowledgements, but it is combinational with respect to `nmi_en`. The region decoder and `cfg_err` are purely combinational. The bench drives inputs on the falling edge and samples registered results at the next falling edge. It samples combinational results one nanosecond after the inputs change, and it walks through the edge count of every multi-step case explicitly.

// File: rtl/smm_pkg.sv
package smm_pkg;
   localparam int unsigned SMM_AW_DEF  = 32;
   localparam int unsigned SMM_SZW_DEF = 5;
   localparam int unsigned SMM_MIN_DEF = 12;
   localparam int unsigned SMM_MAX_DEF = 25;

   // per-cycle SMI decision
   typedef struct packed {
      logic take;
      logic hold;
      logic leave;
   } smi_decision_t;
endpackage

// File: rtl/smm_region_dec.sv
module smm_region_dec #(
   parameter int unsigned AW       = 32,
   parameter int unsigned SZW      = 5,
   parameter int unsigned MIN_LOG2 = 12,
   parameter int unsigned MAX_LOG2 = 25
) (
   input  logic [AW-1:0]  base,
   input  logic [SZW-1:0] size_code,
   input  logic [AW-1:0]  addr,
   output logic           cfg_err,
   output logic           hit
);
   localparam int unsigned CW = 32;

   logic [CW-1:0] code_w;
   logic [AW-1:0] lo_mask;
   logic          code_ok;
   logic          misalign;

   assign code_w = {{(CW-SZW){1'b0}}, size_code};

   genvar gi;
   generate
      for (gi = 0; gi < AW; gi++) begin : g_mask
         assign lo_mask[gi] = (code_w > CW'(gi));
      end
   endgenerate

   assign code_ok  = (code_w >= CW'(MIN_LOG2)) && (code_w <= CW'(MAX_LOG2));
   assign misalign = |(base & lo_mask);
   assign cfg_err  = !code_ok || misalign;
   assign hit      = !cfg_err && (((addr ^ base) & ~lo_mask) == '0);
endmodule

// File: rtl/smm_nmi_latch.sv
module smm_nmi_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_req,
   input  logic nmi_ack,
   input  logic in_smm,
   input  logic nmi_en,
   output logic svc_req
);
   logic held;
   logic held_nx;

   assign svc_req = held && (!in_smm || nmi_en);

   always_comb begin
      held_nx = held;
      if (svc_req && nmi_ack) held_nx = 1'b0;
      if (nmi_req)            held_nx = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) held <= 1'b0;
      else        held <= held_nx;
   end

   // R9
   nmi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |=> held);
   // R8
   nmi_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_req && nmi_ack && !nmi_req) |=> !svc_req);
   // R7
   nmi_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held && in_smm && !nmi_en && !nmi_ack) |=> held);
endmodule

// File: rtl/smm_mode_fsm.sv
module smm_mode_fsm
   import smm_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smi_req,
   input  logic          rsm_req,
   input  logic          rsm_hdr_nested,
   input  logic          nest_en,
   input  logic          cfg_err,
   input  logic [AW-1:0] cfg_base,
   output logic          in_smm,
   output logic          hdr_nested,
   output logic          if_clear,
   output logic [AW-1:0] entry_vec
);
   logic          smi_held;
   logic          rsm_act;
   logic          smi_any;
   smi_decision_t dec;

   assign rsm_act = rsm_req && in_smm;
   assign smi_any = smi_req || smi_held;

   always_comb begin
      dec.leave = rsm_act && !rsm_hdr_nested;
      dec.take  = smi_any && !cfg_err && !rsm_act && (!in_smm || nest_en);
      dec.hold  = smi_req && !cfg_err && !dec.take;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_smm     <= 1'b0;
         hdr_nested <= 1'b0;
         if_clear   <= 1'b0;
         entry_vec  <= '0;
         smi_held   <= 1'b0;
      end else begin
         if_clear <= dec.take;
         if (dec.take) begin
            in_smm     <= 1'b1;
            hdr_nested <= in_smm;
            entry_vec  <= cfg_base;
         end else if (rsm_act) begin
            in_smm <= rsm_hdr_nested;
         end
         if (dec.take)      smi_held <= 1'b0;
         else if (dec.hold) smi_held <= 1'b1;
      end
   end

   // R2
   entry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_smm) |-> if_clear);
   // R3
   cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !in_smm) |=> !in_smm);
   // R4
   nested_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smi_req && in_smm && nest_en && !rsm_req && !cfg_err) |=> (if_clear && hdr_nested));
   // R6
   resume_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_smm && rsm_req && !rsm_hdr_nested) |=> !in_smm);
   // R2
   entry_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (if_clear && !smi_req && !smi_held) |=> !if_clear);
endmodule

// File: rtl/smm_ctrl.sv
module smm_ctrl
   import smm_pkg::*;
#(
   parameter int unsigned AW       = SMM_AW_DEF,
   parameter int unsigned SZW      = SMM_SZW_DEF,
   parameter int unsigned MIN_LOG2 = SMM_MIN_DEF,
   parameter int unsigned MAX_LOG2 = SMM_MAX_DEF
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  cfg_base,
   input  logic [SZW-1:0] cfg_size,
   input  logic           nest_en,
   input  logic           nmi_en,
   input  logic           smi_req,
   input  logic           nmi_req,
   input  logic           nmi_ack,
   input  logic           rsm_req,
   input  logic           rsm_hdr_nested,
   input  logic [AW-1:0]  acc_addr,
   output logic           in_smm,
   output logic           hdr_nested,
   output logic [AW-1:0]  entry_vec,
   output logic           if_clear,
   output logic           nmi_svc_req,
   output logic           cfg_err,
   output logic           acc_in_region,
   output logic           acc_cacheable
);
   localparam int unsigned CODE_SPAN = 1 << SZW;

   generate
      if (MIN_LOG2 < 1 || MIN_LOG2 > MAX_LOG2)
         $error("smm_ctrl: size limits out of order");
      if (MAX_LOG2 >= AW)
         $error("smm_ctrl: region larger than address space");
      if (MAX_LOG2 >= CODE_SPAN)
         $error("smm_ctrl: size code too narrow");
   endgenerate

   logic region_hit;

   smm_region_dec #(
      .AW(AW), .SZW(SZW), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)
   ) u_region (
      .base      (cfg_base),
      .size_code (cfg_size),
      .addr      (acc_addr),
      .cfg_err   (cfg_err),
      .hit       (region_hit)
   );

   assign acc_in_region = region_hit;
   assign acc_cacheable = region_hit;

   smm_mode_fsm #(.AW(AW)) u_mode (
      .clk            (clk),
      .rst_n          (rst_n),
      .smi_req        (smi_req),
      .rsm_req        (rsm_req),
      .rsm_hdr_nested (rsm_hdr_nested),
      .nest_en        (nest_en),
      .cfg_err        (cfg_err),
      .cfg_base       (cfg_base),
      .in_smm         (in_smm),
      .hdr_nested     (hdr_nested),
      .if_clear       (if_clear),
      .entry_vec      (entry_vec)
   );

   smm_nmi_latch u_nmi (
      .clk     (clk),
      .rst_n   (rst_n),
      .nmi_req (nmi_req),
      .nmi_ack (nmi_ack),
      .in_smm  (in_smm),
      .nmi_en  (nmi_en),
      .svc_req (nmi_svc_req)
   );

   // R10
   region_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !acc_in_region);
endmodule

// File: tb/tb_smm_ctrl.sv
module tb_smm_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_base = 32'h0003_0000;
   logic [4:0]  cfg_size = 5'd15;
   logic        nest_en = 1'b0, nmi_en = 1'b0;
   logic        smi_req = 1'b0, nmi_req = 1'b0, nmi_ack = 1'b0;
   logic        rsm_req = 1'b0, rsm_hdr_nested = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        in_smm, hdr_nested, if_clear, nmi_svc_req;
   logic        cfg_err, acc_in_region, acc_cacheable;
   logic [31:0] entry_vec;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   smm_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size(cfg_size),
      .nest_en(nest_en), .nmi_en(nmi_en), .smi_req(smi_req), .nmi_req(nmi_req),
      .nmi_ack(nmi_ack), .rsm_req(rsm_req), .rsm_hdr_nested(rsm_hdr_nested),
      .acc_addr(acc_addr), .in_smm(in_smm), .hdr_nested(hdr_nested),
      .entry_vec(entry_vec), .if_clear(if_clear), .nmi_svc_req(nmi_svc_req),
      .cfg_err(cfg_err), .acc_in_region(acc_in_region), .acc_cacheable(acc_cacheable)
   );

   // {base, size code, addr, expected cfg_err, expected in-region}
   localparam logic [70:0] VEC [0:10] = '{
      {32'h0003_0000, 5'd15, 32'h0003_0000, 1'b0, 1'b1},
      {32'h0003_0000, 5'd15, 32'h0003_7FFF, 1'b0, 1'b1},
      {32'h0003_0000, 5'd15, 32'h0003_8000, 1'b0, 1'b0},
      {32'h0003_0000, 5'd15, 32'h0002_FFFF, 1'b0, 1'b0},
      {32'h0000_0000, 5'd12, 32'h0000_0FFF, 1'b0, 1'b1},
      {32'h0000_0000, 5'd12, 32'h0000_1000, 1'b0, 1'b0},
      {32'h0200_0000, 5'd25, 32'h03FF_FFFF, 1'b0, 1'b1},
      {32'h0100_0000, 5'd25, 32'h0100_0000, 1'b1, 1'b0},
      {32'h0000_0000, 5'd26, 32'h0000_0000, 1'b1, 1'b0},
      {32'h0000_0000, 5'd11, 32'h0000_0000, 1'b1, 1'b0},
      {32'h0003_1000, 5'd15, 32'h0003_1000, 1'b1, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #800000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      @(negedge clk);
      tick();
      tick();
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 in_smm", {31'd0, in_smm}, 0);
      chk("R1 if_clear", {31'd0, if_clear}, 0);
      chk("R1 hdr_nested", {31'd0, hdr_nested}, 0);
      chk("R1 nmi_svc_req", {31'd0, nmi_svc_req}, 0);
      chk("R1 entry_vec", entry_vec, 0);

      // R10 and R3: region table walk
      for (int i = 0; i < 11; i++) begin
         cfg_base = VEC[i][70:39];
         cfg_size = VEC[i][38:34];
         acc_addr = VEC[i][33:2];
         #1;
         chk("R3 cfg_err", {31'd0, cfg_err}, {31'd0, VEC[i][1]});
         chk("R10 in_region", {31'd0, acc_in_region}, {31'd0, VEC[i][0]});
         chk("R10 cacheable", {31'd0, acc_cacheable}, {31'd0, VEC[i][0]});
         @(negedge clk);
      end
      cfg_base = 32'h0003_0000;
      cfg_size = 5'd15;

      // R2 plain entry
      smi_req = 1'b1; tick(); smi_req = 1'b0;
      chk("R2 in_smm", {31'd0, in_smm}, 1);
      chk("R2 if_clear", {31'd0, if_clear}, 1);
      chk("R2 hdr_nested", {31'd0, hdr_nested}, 0);
      chk("R2 entry_vec", entry_vec, 32'h0003_0000);
      tick();
      chk("R2 if_clear one cycle", {31'd0, if_clear}, 0);

      // R5 held SMI while nesting disabled
      smi_req = 1'b1; tick(); smi_req = 1'b0;
      chk("R5 not taken", {31'd0, if_clear}, 0);
      rsm_req = 1'b1; rsm_hdr_nested = 1'b0; tick(); rsm_req = 1'b0;
      chk("R6 resume leaves", {31'd0, in_smm}, 0);
      tick();
      chk("R5 taken after resume", {31'd0, in_smm}, 1);
      chk("R5 if_clear", {31'd0, if_clear}, 1);
      chk("R5 hdr_nested", {31'd0, hdr_nested}, 0);

      // R4 nested entry
      nest_en = 1'b1;
      smi_req = 1'b1; tick(); smi_req = 1'b0;
      chk("R4 if_clear", {31'd0, if_clear}, 1);
      chk("R4 hdr_nested", {31'd0, hdr_nested}, 1);
      chk("R4 in_smm", {31'd0, in_smm}, 1);
      rsm_req = 1'b1; rsm_hdr_nested = 1'b1; tick(); rsm_req = 1'b0;
      chk("R6 nested resume stays", {31'd0, in_smm}, 1);
      rsm_req = 1'b1; rsm_hdr_nested = 1'b0; tick(); rsm_req = 1'b0;
      chk("R6 outer resume leaves", {31'd0, in_smm}, 0);
      nest_en = 1'b0;

      // R6 resume outside the mode ignored
      rsm_req = 1'b1; rsm_hdr_nested = 1'b1; tick(); rsm_req = 1'b0;
      chk("R6 ignored outside", {31'd0, in_smm}, 0);
      tick();
      chk("R6 no entry", {31'd0, in_smm}, 0);

      // R11 resume and SMI together
      smi_req = 1'b1; tick(); smi_req = 1'b0;
      rsm_req = 1'b1; smi_req = 1'b1; rsm_hdr_nested = 1'b0; tick();
      rsm_req = 1'b0; smi_req = 1'b0;
      chk("R11 resume first", {31'd0, in_smm}, 0);
      chk("R11 no entry yet", {31'd0, if_clear}, 0);
      tick();
      chk("R11 SMI taken", {31'd0, in_smm}, 1);
      chk("R11 if_clear", {31'd0, if_clear}, 1);

      // R7/R8 masked NMI in the mode
      nmi_req = 1'b1; tick(); nmi_req = 1'b0;
      chk("R7 masked", {31'd0, nmi_svc_req}, 0);
      nmi_req = 1'b1; tick(); nmi_req = 1'b0;
      nmi_en = 1'b1; #1;
      chk("R7 enable releases", {31'd0, nmi_svc_req}, 1);
      @(negedge clk);
      nmi_ack = 1'b1; tick(); nmi_ack = 1'b0;
      chk("R8 ack clears, extra dropped", {31'd0, nmi_svc_req}, 0);
      tick();
      chk("R8 no second request", {31'd0, nmi_svc_req}, 0);
      nmi_en = 1'b0;
      nmi_req = 1'b1; tick(); nmi_req = 1'b0;
      chk("R7 masked again", {31'd0, nmi_svc_req}, 0);
      rsm_req = 1'b1; rsm_hdr_nested = 1'b0; tick(); rsm_req = 1'b0;
      chk("R7 resume releases", {31'd0, nmi_svc_req}, 1);
      nmi_ack = 1'b1; tick(); nmi_ack = 1'b0;
      chk("R8 ack after resume", {31'd0, nmi_svc_req}, 0);

      // R9 NMI outside the mode
      nmi_req = 1'b1; tick(); nmi_req = 1'b0;
      chk("R9 request", {31'd0, nmi_svc_req}, 1);
      nmi_ack = 1'b1; tick(); nmi_ack = 1'b0;
      chk("R9 ack", {31'd0, nmi_svc_req}, 0);

      // R3 illegal region blocks and does not hold SMI
      cfg_size = 5'd11;
      smi_req = 1'b1; tick(); smi_req = 1'b0;
      chk("R3 bad size blocks", {31'd0, in_smm}, 0);
      cfg_size = 5'd15; cfg_base = 32'h0003_1000;
      smi_req = 1'b1; tick(); smi_req = 1'b0;
      chk("R3 misaligned blocks", {31'd0, in_smm}, 0);
      cfg_base = 32'h0003_0000;
      tick();
      chk("R3 not held", {31'd0, in_smm}, 0);
      chk("R3 no pulse", {31'd0, if_clear}, 0);

      finish_run();
   end
endmodule